// File: doc/BRIEF.md
# UART Frame Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A character enters through a valid/ready handshake and waits in a one-entry holding slot. When the shifter is free it takes the character. It then sends a low start bit, the data bits, an optional parity bit and a stop period, all at a rate set by an external oversampling tick. The tick arrives sixteen times per bit period.

The frame format is chosen at run time with three codes: word length (5 to 8 bits), parity (none, odd, even, forced one or forced zero) and stop length (1, 1.5 or 2 bits). The block reads these codes once, at the start of each character. Two flags report progress. One shows that a frame is on the line. The other shows that the whole transmitter is empty, meaning nothing is being sent and nothing is held. The handshake ready signal separately reports whether the holding slot is free.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, busy is 0, tx_empty is 1 and in_ready is 1; whenever no frame is being sent the line is high.
- R2: A frame starts with one low start bit. The data bits follow, least significant first. The word-length code sets how many bits are sent: 0=5, 1=6, 2=7, 3=8. Data bits above the selected length are never sent.
- R3: The parity code selects the bit sent after the data. 1 gives odd parity and 2 gives even parity, both computed only over the sent data bits. 3 always sends 1 and 4 always sends 0. Codes 0, 5, 6 and 7 send no parity bit.
- R4: The stop period holds the line high. Its length in ticks follows the stop code: 0 gives 16, 1 gives 24, and 2 or 3 give 32. busy stays 1 until the stop period has ended.
- R5: Every start, data and parity bit lasts exactly 16 baud ticks. Clock cycles without a tick do not advance the frame, whatever the spacing between ticks.
- R6: The format codes are captured on the clock edge where a frame starts. Changing them while that frame is on the line has no effect until the next frame.
- R7: in_ready is 1 exactly when the holding slot is empty. A byte is accepted on an edge where in_valid and in_ready are both 1. A held byte starts sending on the first edge at which the shifter is idle, so the line rises after the stop period for at least one cycle before the next start bit.
- R8: busy is 1 only while a frame is being sent. tx_empty is 1 only when no frame is being sent and no byte is held.
- R9: in_valid asserted while in_ready is 0 is ignored: the byte is not accepted, and the held byte and later frames are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| cfg_wlen | input | 2 | Word length code (0..3 = 5..8 bits) |
| cfg_parity | input | 3 | Parity code (0 none, 1 odd, 2 even, 3 one, 4 zero) |
| cfg_stop | input | 2 | Stop length code (0 = 1, 1 = 1.5, 2/3 = 2 bits) |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Holding slot free |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame on the line |
| tx_empty | output | 1 | Nothing sent and nothing held |

## Verification
The hardest state to reach from the ports is a full holding slot while a frame is still going out. In that state three things can happen at once: the format codes change under the running frame, a further in_valid pulse arrives that must be dropped, and the held byte starts on the edge right after the stop period. The stimulus creates it by offering a second byte with a different format immediately after the first is taken. While the slot is still full it pulses in_valid with a different value. The tick spacing is switched to an irregular pattern so that bit lengths are measured in ticks and not in cycles.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {PH_START, PH_DATA, PH_PAR, PH_STOP} tx_phase_e;

  // number of data bits for a word-length code
  function automatic logic [3:0] word_bits(input logic [1:0] wl);
    return 4'd5 + {2'b00, wl};
  endfunction

  // codes 1..4 carry a parity bit
  function automatic logic parity_on(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  // parity bit over the selected data bits only
  function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] wl,
                                      input logic [2:0] m);
    logic [7:0] mask;
    logic       odd_ones;
    mask     = 8'hFF >> (3'd3 - {1'b0, wl});
    odd_ones = ^(d & mask);
    case (m)
      3'd1:    return ~odd_ones;
      3'd2:    return odd_ones;
      3'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // stop period in ticks
  function automatic int stop_ticks(input logic [1:0] s, input int tpb);
    case (s)
      2'd0:    return tpb;
      2'd1:    return tpb + tpb / 2;
      default: return 2 * tpb;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       pop,
  output logic       hold_vld,
  output logic [7:0] hold_data
);

  logic accept;
  assign accept   = in_valid && !hold_vld;
  assign in_ready = !hold_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_data <= '0;
    end else if (accept) begin
      hold_vld  <= 1'b1;
      hold_data <= in_data;
    end else if (pop) begin
      hold_vld  <= 1'b0;
    end
  end

  // a held byte survives until the shifter takes it (R9)
  assert_hold_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && !pop) |=> (hold_vld && $stable(hold_data)));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int TPB = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] ld_data,
  input  logic [1:0] cfg_wlen,
  input  logic [2:0] cfg_parity,
  input  logic [1:0] cfg_stop,
  output logic       txd,
  output logic       active
);
  import uart_tx_pkg::*;

  localparam int CW = $clog2(2 * TPB + 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(TPB - 1);

  tx_phase_e     phase;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [3:0]    nbits_q;
  logic [7:0]    shreg;
  logic          par_en_q;
  logic          par_val_q;
  logic [CW-1:0] stop_last_q;

  // named internal events
  logic [CW-1:0] cur_last;
  logic          bit_done;
  logic          frame_done;
  logic          last_data;

  assign cur_last   = (phase == PH_STOP) ? stop_last_q : BIT_LAST;
  assign bit_done   = active && tick && (cnt == cur_last);
  assign frame_done = bit_done && (phase == PH_STOP);
  assign last_data  = ({1'b0, bit_idx} == (nbits_q - 4'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      phase       <= PH_START;
      cnt         <= '0;
      bit_idx     <= '0;
      nbits_q     <= 4'd8;
      shreg       <= '0;
      par_en_q    <= 1'b0;
      par_val_q   <= 1'b0;
      stop_last_q <= BIT_LAST;
    end else if (load) begin
      active      <= 1'b1;
      phase       <= PH_START;
      cnt         <= '0;
      bit_idx     <= '0;
      shreg       <= ld_data;
      nbits_q     <= word_bits(cfg_wlen);
      par_en_q    <= parity_on(cfg_parity);
      par_val_q   <= parity_bit(ld_data, cfg_wlen, cfg_parity);
      stop_last_q <= CW'(stop_ticks(cfg_stop, TPB) - 1);
    end else if (active && tick) begin
      if (bit_done) begin
        cnt <= '0;
        case (phase)
          PH_START: phase <= PH_DATA;
          PH_DATA: begin
            shreg <= shreg >> 1;
            if (last_data) phase <= par_en_q ? PH_PAR : PH_STOP;
            else           bit_idx <= bit_idx + 3'd1;
          end
          PH_PAR:  phase  <= PH_STOP;
          default: active <= 1'b0;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (!active) txd = 1'b1;
    else begin
      case (phase)
        PH_START: txd = 1'b0;
        PH_DATA:  txd = shreg[0];
        PH_PAR:   txd = par_val_q;
        default:  txd = 1'b1;
      endcase
    end
  end

  // a frame opens with a low line (R2)
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !txd);

  // idle line is high (R1)
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> txd);

  // tick counter never passes the end of the current bit (R5)
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= cur_last));

  // cycles without a tick leave the frame position alone (R5)
  assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !load) |=> ($stable(cnt) && $stable(phase)));

  // captured format is frozen between loads (R6)
  assert_fmt_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(nbits_q) && $stable(par_en_q) && $stable(stop_last_q)));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] cfg_wlen,
  input  logic [2:0] cfg_parity,
  input  logic [1:0] cfg_stop,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       txd,
  output logic       busy,
  output logic       tx_empty
);

  logic       hold_vld;
  logic [7:0] hold_data;
  logic       active;
  logic       load;

  assign load     = !active && hold_vld;
  assign busy     = active;
  assign tx_empty = !active && !hold_vld;

  uart_tx_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pop       (load),
    .hold_vld  (hold_vld),
    .hold_data (hold_data)
  );

  uart_tx_shifter #(.TPB(TICKS_PER_BIT)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .load       (load),
    .ld_data    (hold_data),
    .cfg_wlen   (cfg_wlen),
    .cfg_parity (cfg_parity),
    .cfg_stop   (cfg_stop),
    .txd        (txd),
    .active     (active)
  );

  // empty implies idle shifter and free slot (R8)
  assert_empty_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (!busy && in_ready));

  // a held byte starts on the first idle edge (R7)
  assert_prompt_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_ready) |=> (busy && in_ready));

endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic [2:0] cfg_parity = 3'd0;
  logic [1:0] cfg_stop = 2'd0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready, txd, busy, tx_empty;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int cyc = 0;
  bit tick_irregular = 0;

  // reference model state
  bit         m_busy = 0;
  bit         m_hold = 0;
  logic [7:0] m_data = 8'h00;
  bit         q_lvl[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  uart_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_wlen(cfg_wlen), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .txd(txd), .busy(busy), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // frame built from the requirements, one entry per tick
  task automatic push_bits(input bit lvl, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      q_lvl.push_back(lvl);
      q_tag.push_back(tag);
    end
  endtask

  task automatic build_frame(input logic [7:0] d);
    int nb, ones, st;
    nb = 5 + int'(cfg_wlen);
    ones = 0;
    push_bits(1'b0, 16, "R2");
    for (int i = 0; i < nb; i++) begin
      push_bits(d[i], 16, "R2");
      if (d[i]) ones++;
    end
    case (cfg_parity)
      3'd1: push_bits((ones % 2) == 0, 16, "R3");
      3'd2: push_bits((ones % 2) == 1, 16, "R3");
      3'd3: push_bits(1'b1, 16, "R3");
      3'd4: push_bits(1'b0, 16, "R3");
      default: ;
    endcase
    st = (cfg_stop == 2'd0) ? 16 : (cfg_stop == 2'd1) ? 24 : 32;
    push_bits(1'b1, st, "R4");
  endtask

  always @(posedge clk) begin : model
    bit acc;
    if (!rst_n) begin
      m_busy = 0; m_hold = 0;
      q_lvl.delete(); q_tag.delete();
    end else begin
      acc = in_valid && !m_hold;
      if (!m_busy && m_hold) begin
        build_frame(m_data);   // format taken at start (R6)
        m_busy = 1; m_hold = 0;
      end else if (m_busy && baud_tick) begin
        void'(q_lvl.pop_front());
        void'(q_tag.pop_front());
        if (q_lvl.size() == 0) m_busy = 0;
      end
      if (acc) begin m_hold = 1; m_data = in_data; end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit    exp_txd;
      string tag;
      exp_txd = m_busy ? q_lvl[0] : 1'b1;
      tag     = m_busy ? q_tag[0] : "R1";
      chk(txd == exp_txd, tag, "txd", txd, exp_txd);
      chk(busy == m_busy, "R8", "busy", busy, m_busy);
      chk(tx_empty == (!m_busy && !m_hold), "R8", "tx_empty", tx_empty, !m_busy && !m_hold);
      chk(in_ready == !m_hold, "R7", "in_ready", in_ready, !m_hold);
    end
  end

  // baud tick generator: regular or irregular spacing (R5)
  always @(negedge clk) begin
    #1;
    cyc++;
    if (!tick_irregular) baud_tick = (cyc % 2) == 0;
    else                 baud_tick = ((cyc * 7) % 5) < 2 && (cyc % 11) != 0;
  end

  task automatic send(input logic [7:0] d, input logic [1:0] w,
                      input logic [2:0] p, input logic [1:0] s);
    do begin @(negedge clk); #2; end while (!in_ready);
    in_data = d; cfg_wlen = w; cfg_parity = p; cfg_stop = s;
    in_valid = 1'b1;
    @(negedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #2; end while (!tx_empty);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", 0, 1);
      finish_up();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #2;
    // reset state (R1)
    chk(txd == 1'b1, "R1", "reset txd", txd, 1);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(tx_empty == 1'b1, "R1", "reset tx_empty", tx_empty, 1);
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);

    // R2 eight bits, no parity, one stop
    send(8'hA5, 2'd3, 3'd0, 2'd0); wait_idle();
    // R2 R3 five bits (high bits dropped), odd parity, 1.5 stop (R4)
    send(8'hF3, 2'd0, 3'd1, 2'd1); wait_idle();
    // R3 even parity, six bits, two stop
    send(8'h2C, 2'd1, 3'd2, 2'd2); wait_idle();
    // R3 forced one / forced zero; R4 code 3
    send(8'h00, 2'd2, 3'd3, 2'd0); wait_idle();
    send(8'h7F, 2'd3, 3'd4, 2'd3); wait_idle();
    // R3 reserved parity code sends no parity bit
    send(8'h81, 2'd3, 3'd5, 2'd0); wait_idle();

    // R5 irregular tick spacing
    tick_irregular = 1;
    send(8'h96, 2'd3, 3'd1, 2'd1); wait_idle();
    tick_irregular = 0;

    // R6 R7 R9: second byte held with a new format while the first runs,
    // then an extra offer while the slot is full
    send(8'h11, 2'd3, 3'd2, 2'd0);
    send(8'h22, 2'd0, 3'd3, 2'd2);
    @(negedge clk); #2;
    chk(in_ready == 1'b0, "R9", "slot full before extra offer", in_ready, 0);
    in_data = 8'h5A; in_valid = 1'b1;
    @(negedge clk); #2;
    in_valid = 1'b0;
    cfg_wlen = 2'd1; cfg_parity = 3'd0; cfg_stop = 2'd1;
    wait_idle();

    // R2 R3 R4 sweep of word length and parity codes
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 5; p++) begin
        send(8'(w * 37 + p * 53 + 11), 2'(w), 3'(p), 2'((w + p) % 4));
      end
    end
    wait_idle();
    repeat (5) @(negedge clk);
    finish_up();
  end

endmodule